// File: doc/BRIEF.md
# Condition-Code Register and Branch Resolver

This block keeps the processor's status flags in one clocked 8-bit register and decides, from a 4-bit condition selector, whether a conditional branch is taken. The flags are carry (C), overflow (V), zero (Z), negative (N) and the interrupt mask (I). Three spare upper bits exist only so that the register fills a full byte. The ALU writes any subset of N, Z, V and C through a per-flag write mask. Separate commands set or clear C, V or I on their own. A transfer command loads the whole byte from an accumulator value, and the current byte is always visible on a read-out port.

The branch resolver is purely combinational and works on the registered flags. It covers the simple single-flag tests, always and never, the signed relations built from N XOR V, and the unsigned relations built from C and Z. The selector codes come in pairs: the odd code of each pair is the logical inverse of the even one.

Top module: `ccr_branch_unit`

## Requirements
- R1: While reset is high, the register takes the value 0xF0 on each clock edge. The byte layout, from bit 7 down to bit 0, is S, X, H, I, N, Z, V, C. The three spares S, X and H and the mask I reset to 1, and N, Z, V and C reset to 0.
- R2: On each edge, every flag whose bit in `alu_we` is 1 takes the matching bit of `alu_flags`. Bit 3 selects N, bit 2 Z, bit 1 V and bit 0 C. Flags whose write-enable bit is 0 keep their value.
- R3: `cmd` is decoded as 0 no-op, 1 clear C, 2 set C, 3 clear V, 4 set V, 5 clear I, 6 set I, 7 load. A set or clear command acts on the next edge and wins over an ALU update of the same flag in that cycle. ALU updates of the other flags still apply.
- R4: Command 7 replaces all 8 bits with `acc_in` on the next edge, and any ALU update in that cycle is discarded.
- R5: `ccr_out` always shows the full register byte in the R1 layout.
- R6: `take` for `cond` is: 0 always, 1 never, 4 C=0, 5 C=1, 6 Z=0, 7 Z=1, 8 V=0, 9 V=1, 10 N=0, 11 N=1.
- R7: For signed relations, `cond` 12 (greater-or-equal) is taken when N XOR V is 0 and 13 (less-than) when it is 1. `cond` 14 (greater-than) is taken when Z OR (N XOR V) is 0 and 15 (less-or-equal) when it is 1.
- R8: For unsigned relations, `cond` 2 (higher) is taken when C OR Z is 0 and 3 (lower-or-same) when it is 1. Codes 4 and 5 also serve as higher-or-same and lower.
- R9: Bits S, X and H change only through the load command or reset.
- R10: `take` depends only on `cond` and the registered flags. A flag write shows up in `take` from the edge that stores it, and not in the cycle in which it is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_we | input | 4 | Per-flag write enables for N, Z, V, C (bits 3..0) |
| alu_flags | input | 4 | Flag values from the ALU for N, Z, V, C (bits 3..0) |
| cmd | input | 3 | Explicit flag command (R3 encoding) |
| acc_in | input | 8 | Accumulator byte for the load command |
| cond | input | 4 | Branch condition selector |
| ccr_out | output | 8 | Current register byte |
| take | output | 1 | Branch taken |

## Verification
All 16 combinations of N, Z, V and C are loaded, and every condition selector is tested against each one. This exposes a resolver that swaps a signed relation with its unsigned counterpart, or that forgets Z in greater-than. A cycle that carries an ALU write to C together with a clear-C command would leave C set if the priority were reversed. A load that arrives with a full-mask ALU write would leave the ALU's low nibble behind if the load did not win. The bench also samples `take` before and after the edge that writes Z. A resolver fed from the next-state value rather than the stored flags would answer one cycle too early.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int CCR_W  = 8;
    localparam int FLAG_W = 4;
    localparam int COND_W = 4;
    localparam logic [CCR_W-1:0] CCR_RESET = 8'hF0;

    // bit positions inside the register byte
    localparam int POS_C = 0;
    localparam int POS_V = 1;
    localparam int POS_Z = 2;
    localparam int POS_N = 3;
    localparam int POS_I = 4;

    typedef struct packed {
        logic s;
        logic x;
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_CLR_C = 3'd1,
        CMD_SET_C = 3'd2,
        CMD_CLR_V = 3'd3,
        CMD_SET_V = 3'd4,
        CMD_CLR_I = 3'd5,
        CMD_SET_I = 3'd6,
        CMD_LOAD  = 3'd7
    } flag_cmd_e;

    // even member of each selector pair; odd member is its inverse
    typedef enum logic [2:0] {
        PAIR_ALWAYS = 3'd0,
        PAIR_HI     = 3'd1,
        PAIR_CC     = 3'd2,
        PAIR_NE     = 3'd3,
        PAIR_VC     = 3'd4,
        PAIR_PL     = 3'd5,
        PAIR_GE     = 3'd6,
        PAIR_GT     = 3'd7
    } cond_pair_e;

    function automatic logic pair_base(input cond_pair_e p, input ccr_t f);
        logic lt_s;
        lt_s = f.n ^ f.v;
        case (p)
            PAIR_ALWAYS: pair_base = 1'b1;
            PAIR_HI:     pair_base = ~(f.c | f.z);
            PAIR_CC:     pair_base = ~f.c;
            PAIR_NE:     pair_base = ~f.z;
            PAIR_VC:     pair_base = ~f.v;
            PAIR_PL:     pair_base = ~f.n;
            PAIR_GE:     pair_base = ~lt_s;
            PAIR_GT:     pair_base = ~(f.z | lt_s);
            default:     pair_base = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ccr_flag_reg.sv
module ccr_flag_reg
    import ccr_pkg::*;
#(
    parameter int W  = CCR_W,
    parameter int FW = FLAG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] alu_we,
    input  logic [FW-1:0] alu_flags,
    input  flag_cmd_e     cmd,
    input  logic [W-1:0]  acc_in,
    output logic [W-1:0]  q
);
    logic [W-1:0] alu_merged;
    logic [W-1:0] nxt;

    // ALU write under mask, one lane per arithmetic flag
    for (genvar k = 0; k < W; k++) begin : g_lane
        if (k < FW) begin : g_alu
            assign alu_merged[k] = alu_we[k] ? alu_flags[k] : q[k];
        end else begin : g_keep
            assign alu_merged[k] = q[k];
        end
    end

    // explicit commands are applied on top of the ALU result
    always_comb begin
        nxt = alu_merged;
        case (cmd)
            CMD_CLR_C: nxt[POS_C] = 1'b0;
            CMD_SET_C: nxt[POS_C] = 1'b1;
            CMD_CLR_V: nxt[POS_V] = 1'b0;
            CMD_SET_V: nxt[POS_V] = 1'b1;
            CMD_CLR_I: nxt[POS_I] = 1'b0;
            CMD_SET_I: nxt[POS_I] = 1'b1;
            CMD_LOAD:  nxt        = acc_in;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= CCR_RESET;
        else     q <= nxt;
    end
endmodule

// File: rtl/ccr_branch_eval.sv
module ccr_branch_eval
    import ccr_pkg::*;
#(
    parameter int CW = COND_W
) (
    input  ccr_t          flags,
    input  logic [CW-1:0] cond,
    output logic          take
);
    cond_pair_e pair;

    always_comb begin
        pair = cond_pair_e'(cond[CW-1:1]);
        take = pair_base(pair, flags) ^ cond[0];
    end
endmodule

// File: rtl/ccr_branch_unit.sv
module ccr_branch_unit
    import ccr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FLAG_W-1:0]  alu_we,
    input  logic [FLAG_W-1:0]  alu_flags,
    input  logic [2:0]         cmd,
    input  logic [CCR_W-1:0]   acc_in,
    input  logic [COND_W-1:0]  cond,
    output logic [CCR_W-1:0]   ccr_out,
    output logic               take
);
    logic [CCR_W-1:0] reg_q;

    ccr_flag_reg #(.W(CCR_W), .FW(FLAG_W)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .alu_we    (alu_we),
        .alu_flags (alu_flags),
        .cmd       (flag_cmd_e'(cmd)),
        .acc_in    (acc_in),
        .q         (reg_q)
    );

    ccr_branch_eval #(.CW(COND_W)) u_eval (
        .flags (ccr_t'(reg_q)),
        .cond  (cond),
        .take  (take)
    );

    assign ccr_out = reg_q;
endmodule

// File: rtl/ccr_branch_unit_chk.sv
module ccr_branch_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] alu_we,
    input logic [3:0] alu_flags,
    input logic [2:0] cmd,
    input logic [7:0] acc_in,
    input logic [3:0] cond,
    input logic [7:0] ccr_out,
    input logic       take
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1: register holds reset value after a reset edge
    always_ff @(posedge clk) begin
        if (rst_seen === 1'b1)
            a_r1_reset_value: assert (ccr_out == 8'hF0);
    end

    a_r2_hold_no_write: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd0 && alu_we == 4'd0) |=> $stable(ccr_out));

    a_r2_z_write: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd0 && alu_we[2]) |=> (ccr_out[2] == $past(alu_flags[2])));

    a_r3_clr_c_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1) |=> !ccr_out[0]);

    a_r3_set_c_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2) |=> ccr_out[0]);

    a_r3_set_i: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd6) |=> ccr_out[4]);

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd7) |=> (ccr_out == $past(acc_in)));

    a_r6_always: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'd0) |-> take);

    a_r6_never: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'd1) |-> !take);

    a_r9_spares: assert property (@(posedge clk) disable iff (rst)
        (cmd != 3'd7) |=> (ccr_out[7:5] == $past(ccr_out[7:5])));
endmodule

bind ccr_branch_unit ccr_branch_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .alu_we    (alu_we),
    .alu_flags (alu_flags),
    .cmd       (cmd),
    .acc_in    (acc_in),
    .cond      (cond),
    .ccr_out   (ccr_out),
    .take      (take)
);

// File: tb/ccr_branch_unit_bench.sv
module ccr_branch_unit_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] alu_we;
    logic [3:0] alu_flags;
    logic [2:0] cmd;
    logic [7:0] acc_in;
    logic [3:0] cond;
    logic [7:0] ccr_out;
    logic       take;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ccr_branch_unit u_ccr_branch_unit (
        .clk(clk), .rst(rst), .alu_we(alu_we), .alu_flags(alu_flags),
        .cmd(cmd), .acc_in(acc_in), .cond(cond),
        .ccr_out(ccr_out), .take(take)
    );

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // one edge with given inputs; returns at the following negedge
    task automatic step(input logic [3:0] we, input logic [3:0] fl,
                        input logic [2:0] c, input logic [7:0] a);
        alu_we = we; alu_flags = fl; cmd = c; acc_in = a;
        @(negedge clk);
        alu_we = 4'd0; alu_flags = 4'd0; cmd = 3'd0; acc_in = 8'd0;
    endtask

    // independent model of the branch relations, flags as {n,z,v,c}
    function automatic logic model_take(input logic [3:0] sel, input logic [3:0] f);
        logic n, z, v, c;
        {n, z, v, c} = f;
        case (sel)
            4'd0:  return 1'b1;
            4'd1:  return 1'b0;
            4'd2:  return (c == 1'b0) && (z == 1'b0);
            4'd3:  return c || z;
            4'd4:  return c == 1'b0;
            4'd5:  return c == 1'b1;
            4'd6:  return z == 1'b0;
            4'd7:  return z == 1'b1;
            4'd8:  return v == 1'b0;
            4'd9:  return v == 1'b1;
            4'd10: return n == 1'b0;
            4'd11: return n == 1'b1;
            4'd12: return n == v;
            4'd13: return n != v;
            4'd14: return (z == 1'b0) && (n == v);
            default: return z || (n != v);
        endcase
    endfunction

    task automatic t_reset;
        rst = 1'b1;
        step(4'hF, 4'hF, 3'd2, 8'h00);
        step(4'h0, 4'h0, 3'd0, 8'h00);
        rst = 1'b0;
        chk8("R1 reset value", ccr_out, 8'hF0);
        chk8("R5 readout after reset", ccr_out, 8'hF0);
    endtask

    task automatic t_alu_mask;
        step(4'b0101, 4'b1111, 3'd0, 8'h00);
        chk8("R2 masked write Z,C", ccr_out, 8'hF5);
        step(4'b0000, 4'b0000, 3'd0, 8'h00);
        chk8("R2 no-write hold", ccr_out, 8'hF5);
        step(4'b1010, 4'b0000, 3'd0, 8'h00);
        chk8("R2 write zeros to N,V", ccr_out, 8'hF5);
    endtask

    task automatic t_commands;
        step(4'h0, 4'h0, 3'd4, 8'h00); chk8("R3 set V", ccr_out, 8'hF7);
        step(4'h0, 4'h0, 3'd1, 8'h00); chk8("R3 clear C", ccr_out, 8'hF6);
        step(4'h0, 4'h0, 3'd5, 8'h00); chk8("R3 clear I", ccr_out, 8'hE6);
        step(4'h0, 4'h0, 3'd6, 8'h00); chk8("R3 set I", ccr_out, 8'hF6);
        step(4'h0, 4'h0, 3'd2, 8'h00); chk8("R3 set C", ccr_out, 8'hF7);
        step(4'h0, 4'h0, 3'd3, 8'h00); chk8("R3 clear V", ccr_out, 8'hF5);
    endtask

    task automatic t_priority;
        // ALU sets N and C, clears Z,V; clear-C command overrides C only
        step(4'hF, 4'b1001, 3'd1, 8'h00);
        chk8("R3 clear C beats ALU", ccr_out, 8'hF8);
        // ALU clears V, set-V command overrides
        step(4'hF, 4'b0100, 3'd4, 8'h00);
        chk8("R3 set V beats ALU", ccr_out, 8'hF6);
    endtask

    task automatic t_load;
        step(4'hF, 4'hF, 3'd7, 8'h0A);
        chk8("R4 load beats ALU", ccr_out, 8'h0A);
        step(4'hF, 4'hF, 3'd0, 8'h00);
        chk8("R9 spares kept on ALU write", ccr_out, 8'h0F);
        step(4'h0, 4'h0, 3'd6, 8'h00);
        chk8("R9 spares kept on set I", ccr_out, 8'h1F);
        step(4'h0, 4'h0, 3'd7, 8'hA5);
        chk8("R4 load pattern", ccr_out, 8'hA5);
    endtask

    task automatic t_branch_all;
        for (int f = 0; f < 16; f++) begin
            step(4'h0, 4'h0, 3'd7, {4'hF, 4'(f)});
            for (int s = 0; s < 16; s++) begin
                cond = 4'(s);
                #1;
                if (s < 2 || (s >= 4 && s < 12))
                    chk1($sformatf("R6 cond %0d flags %h", s, f), take, model_take(4'(s), 4'(f)));
                else if (s >= 12)
                    chk1($sformatf("R7 cond %0d flags %h", s, f), take, model_take(4'(s), 4'(f)));
                else
                    chk1($sformatf("R8 cond %0d flags %h", s, f), take, model_take(4'(s), 4'(f)));
            end
        end
    endtask

    task automatic t_timing;
        step(4'hF, 4'h0, 3'd0, 8'h00);
        cond = 4'd7;
        #1;
        chk1("R10 eq before write", take, 1'b0);
        alu_we = 4'b0100; alu_flags = 4'b0100;
        #1;
        chk1("R10 eq not early", take, 1'b0);
        @(negedge clk);
        alu_we = 4'd0; alu_flags = 4'd0;
        chk1("R10 eq after edge", take, 1'b1);
    endtask

    initial begin
        rst = 1'b1; alu_we = 4'd0; alu_flags = 4'd0; cmd = 3'd0;
        acc_in = 8'd0; cond = 4'd0;
        @(negedge clk);
        t_reset;
        t_alu_mask;
        t_commands;
        t_priority;
        t_load;
        t_branch_all;
        t_timing;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule